// File: doc/BRIEF.md
# Flash programming status and polling

This block is the status and completion-polling logic of a page-programmed non-volatile memory. A programming front end sends it three commands: load one byte into the page buffer, program the buffered bytes into a page, and erase a page. A fixed-length cycle counter times each program or erase cycle. A small register array stands in for the memory cells. The block reports progress in two ways. The first is a four-flag status byte, which can be read at any time. The second is data polling: while a cycle runs, one read location returns a value that differs from its final content, and the host can watch for that value to change.

A brownout detector input can stop programming. While the supply is low, writes are inhibited. A cycle that is running when the supply drops is abandoned and leaves the cells untouched. The SUCCESS flag then stays low as a record of the failure until a new cycle is accepted. A single write-lock input blocks program and erase commands.

Top module: `nvm_prog_status`

## Requirements
- R1: The status byte has LOAD at bit 3, SUCCESS at bit 2, WRTINH at bit 1 and BUSY at bit 0. Bits 7 to 4 read as zero. After reset, with the supply good, the status byte is 0x0F.
- R2: A load command (cmd_op 2'b01) writes cmd_data into the page buffer at offset cmd_addr[PAGE_W-1:0] and drives LOAD low. An accepted program command drives LOAD high again. An erase leaves LOAD unchanged.
- R3: Program (2'b10) and erase (2'b11) commands are accepted only while BUSY is high and wr_lock is low. Load commands are accepted only while BUSY is high. Any other command has no effect on the flags or on the array.
- R4: An accepted program or erase drives BUSY and SUCCESS low from the next cycle. BUSY stays low for exactly CYCLE_LEN clock cycles when no brownout occurs.
- R5: A program cycle that completes writes every buffer byte loaded since the last program into the target page (page number cmd_addr[ADDR_W-1:PAGE_W]). Bytes that were not loaded keep their values, and SUCCESS goes high.
- R6: An erase cycle that completes sets every byte of the target page to 0xFF and drives SUCCESS high.
- R7: WRTINH equals the inverse of bod_low. BUSY is low whenever bod_low is high.
- R8: If bod_low is high at any clock edge during a cycle, the cycle ends with the array unchanged and the buffer emptied. SUCCESS stays low until the next accepted cycle, and BUSY returns high once bod_low falls.
- R9: During a program cycle, a read of the target page at the offset of the last loaded byte returns that byte with bit DATA_W-1 inverted. After the cycle ends, the read returns the stored value.
- R10: When several bytes are loaded, the polled location and value are those of the byte loaded last, not of the highest offset.
- R11: During an erase cycle, a read of any address in the target page returns 0x7F.
- R12: A read of any other address returns the array content, including while a cycle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 01 load, 10 program, 11 erase |
| cmd_addr | input | ADDR_W | Byte address (load) or any address in the target page |
| cmd_data | input | DATA_W | Byte carried by a load command |
| wr_lock | input | 1 | Blocks program and erase commands |
| bod_low | input | 1 | Brownout detector: supply below the programming minimum |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, with polling override |
| status | output | 8 | Status byte |

## Verification
The main function is exercised with four patterns, and each one separates a different kind of error.
- A multi-byte load in non-ascending offset order shows whether the polled value follows load order or address order, and whether unloaded bytes stay intact.
- An erase of a page that holds data separates the whole-page 0x7F poll from the single-location program poll.
- A brownout in the middle of a program cycle, and a brownout while idle, separate an abandoned cycle from a completed one, and show whether the failure record holds after the supply recovers.
- Commands issued while busy, locked or in brownout show whether each one is ignored, by reading the flags and the array afterwards.

// File: rtl/nvm_ps_pkg.sv
package nvm_ps_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_PROG  = 2'b10,
    OP_ERASE = 2'b11
  } nvm_op_e;

  typedef enum logic {
    CYC_PROG  = 1'b0,
    CYC_ERASE = 1'b1
  } cyc_kind_e;

  localparam int ST_LOAD = 3;
  localparam int ST_SUCC = 2;
  localparam int ST_WINH = 1;
  localparam int ST_BUSY = 0;

endpackage

// File: rtl/nvm_rst_sync.sv
module nvm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/nvm_page_buf.sv
module nvm_page_buf #(
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_en,
  input  logic [PAGE_W-1:0]            ld_off,
  input  logic [DATA_W-1:0]            ld_data,
  input  logic                         clr_mask,
  output logic [(1<<PAGE_W)*DATA_W-1:0] buf_flat,
  output logic [(1<<PAGE_W)-1:0]       buf_mask,
  output logic [PAGE_W-1:0]            last_off,
  output logic [DATA_W-1:0]            last_data
);

  localparam int PB = 1 << PAGE_W;

  logic [PB-1:0]     mask_q, mask_d;
  logic [PAGE_W-1:0] loff_q;
  logic [DATA_W-1:0] ldat_q;

  always_comb begin
    mask_d = mask_q;
    if (clr_mask) mask_d = '0;
    else if (ld_en) mask_d[ld_off] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loff_q <= '0;
      ldat_q <= '0;
    end else if (ld_en) begin
      loff_q <= ld_off;
      ldat_q <= ld_data;
    end
  end

  for (genvar i = 0; i < PB; i++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    logic              we;
    assign we = ld_en && (ld_off == PAGE_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  byte_q <= '0;
      else if (we) byte_q <= ld_data;
    end
    assign buf_flat[i*DATA_W +: DATA_W] = byte_q;
  end

  assign buf_mask  = mask_q;
  assign last_off  = loff_q;
  assign last_data = ldat_q;

endmodule

// File: rtl/nvm_cycle_timer.sv
module nvm_cycle_timer #(
  parameter int CYCLE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic active,
  output logic done
);

  localparam int CNT_W = $clog2(CYCLE_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_LEN - 1);

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (act_q) begin
      if (abort)              act_d = 1'b0;
      else if (cnt_q == '0)   act_d = 1'b0;
      else                    cnt_d = cnt_q - 1'b1;
    end else if (start) begin
      act_d = 1'b1;
      cnt_d = LAST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active = act_q;
  assign done   = act_q && (cnt_q == '0) && !abort;

endmodule

// File: rtl/nvm_status_flags.sv
module nvm_status_flags
  import nvm_ps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_clr,
  input  logic       load_set,
  input  logic       cyc_start,
  input  logic       cyc_done,
  input  logic       cyc_active,
  input  logic       bod_low,
  output logic [7:0] status
);

  logic load_q, load_d;
  logic succ_q, succ_d;

  always_comb begin
    load_d = load_q;
    if (load_clr)      load_d = 1'b0;
    else if (load_set) load_d = 1'b1;
    succ_d = succ_q;
    if (cyc_start)     succ_d = 1'b0;
    else if (cyc_done) succ_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b1;
      succ_q <= 1'b1;
    end else begin
      load_q <= load_d;
      succ_q <= succ_d;
    end
  end

  always_comb begin
    status          = 8'h00;
    status[ST_LOAD] = load_q;
    status[ST_SUCC] = succ_q;
    status[ST_WINH] = !bod_low;
    status[ST_BUSY] = !(cyc_active || bod_low);
  end

endmodule

// File: rtl/nvm_mem_array.sv
module nvm_mem_array #(
  parameter int ADDR_W = 6,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit_prog,
  input  logic                          commit_erase,
  input  logic [ADDR_W-PAGE_W-1:0]      tgt_page,
  input  logic [(1<<PAGE_W)*DATA_W-1:0] buf_flat,
  input  logic [(1<<PAGE_W)-1:0]        buf_mask,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_word
);

  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam int PB        = 1 << PAGE_W;
  localparam int PG_W      = ADDR_W - PAGE_W;

  logic [DATA_W-1:0] cell_w [MEM_BYTES];

  for (genvar j = 0; j < MEM_BYTES; j++) begin : g_cell
    localparam int PG  = j / PB;
    localparam int OFF = j % PB;
    logic [DATA_W-1:0] cell_q, cell_d;
    logic              hit, en;

    assign hit = (tgt_page == PG_W'(PG));
    assign en  = hit && (commit_erase || (commit_prog && buf_mask[OFF]));

    always_comb begin
      cell_d = cell_q;
      if (commit_erase)     cell_d = '1;
      else if (commit_prog) cell_d = buf_flat[OFF*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cell_q <= '1;
      else if (en) cell_q <= cell_d;
    end

    assign cell_w[j] = cell_q;
  end

  assign rd_word = cell_w[rd_addr];

endmodule

// File: rtl/nvm_prog_status.sv
module nvm_prog_status
  import nvm_ps_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int PAGE_W    = 3,
  parameter int DATA_W    = 8,
  parameter int CYCLE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              wr_lock,
  input  logic              bod_low,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [7:0]        status
);

  localparam int PB   = 1 << PAGE_W;
  localparam int PG_W = ADDR_W - PAGE_W;
  localparam logic [DATA_W-1:0] MSB_MASK   = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] ERASE_POLL = ~MSB_MASK;

  logic rst_n_int;

  nvm_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_int)
  );

  nvm_op_e op;
  logic    ready, load_acc, cyc_start;
  logic    active, done, abort;
  logic    commit_prog, commit_erase, clr_mask;
  cyc_kind_e         kind_q, kind_d;
  logic [PG_W-1:0]   page_q, page_d;
  logic [PB*DATA_W-1:0] buf_flat;
  logic [PB-1:0]     buf_mask;
  logic [PAGE_W-1:0] last_off;
  logic [DATA_W-1:0] last_data, mem_word;

  assign op        = nvm_op_e'(cmd_op);
  assign ready     = status[ST_BUSY];
  assign load_acc  = cmd_valid && ready && (op == OP_LOAD);
  assign cyc_start = cmd_valid && ready && !wr_lock &&
                     ((op == OP_PROG) || (op == OP_ERASE));
  assign abort     = active && bod_low;

  always_comb begin
    kind_d = kind_q;
    page_d = page_q;
    if (cyc_start) begin
      kind_d = (op == OP_ERASE) ? CYC_ERASE : CYC_PROG;
      page_d = cmd_addr[ADDR_W-1:PAGE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      kind_q <= CYC_PROG;
      page_q <= '0;
    end else begin
      kind_q <= kind_d;
      page_q <= page_d;
    end
  end

  assign commit_prog  = done && (kind_q == CYC_PROG);
  assign commit_erase = done && (kind_q == CYC_ERASE);
  assign clr_mask     = active && (kind_q == CYC_PROG) && (done || bod_low);

  nvm_cycle_timer #(.CYCLE_LEN(CYCLE_LEN)) u_timer (
    .clk   (clk),
    .rst_n (rst_n_int),
    .start (cyc_start),
    .abort (abort),
    .active(active),
    .done  (done)
  );

  nvm_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .ld_en    (load_acc),
    .ld_off   (cmd_addr[PAGE_W-1:0]),
    .ld_data  (cmd_data),
    .clr_mask (clr_mask),
    .buf_flat (buf_flat),
    .buf_mask (buf_mask),
    .last_off (last_off),
    .last_data(last_data)
  );

  nvm_status_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load_clr  (load_acc),
    .load_set  (cyc_start && (op == OP_PROG)),
    .cyc_start (cyc_start),
    .cyc_done  (done),
    .cyc_active(active),
    .bod_low   (bod_low),
    .status    (status)
  );

  nvm_mem_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_mem (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .commit_prog (commit_prog),
    .commit_erase(commit_erase),
    .tgt_page    (page_q),
    .buf_flat    (buf_flat),
    .buf_mask    (buf_mask),
    .rd_addr     (rd_addr),
    .rd_word     (mem_word)
  );

  logic page_hit;
  assign page_hit = active && (rd_addr[ADDR_W-1:PAGE_W] == page_q);

  always_comb begin
    rd_data = mem_word;
    if (page_hit) begin
      if (kind_q == CYC_ERASE)
        rd_data = ERASE_POLL;
      else if (rd_addr[PAGE_W-1:0] == last_off)
        rd_data = last_data ^ MSB_MASK;
    end
  end

endmodule

// File: rtl/nvm_prog_status_chk.sv
module nvm_prog_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       wr_lock,
  input logic       bod_low,
  input logic [7:0] status
);

  // R1
  hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:4] == 4'h0);

  // R2
  load_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b01 && status[0]) |=> !status[3]);

  // R3
  lock_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[1] && wr_lock && status[0] && status[2]) |=> status[2]);

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[1] && !wr_lock && status[0]) |=> (!status[0] && !status[2]));

  // R7
  bod_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bod_low |-> (!status[0] && !status[1]));

  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bod_low && !status[2]) |=> !status[2]);

endmodule

bind nvm_prog_status nvm_prog_status_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n_int),
  .cmd_valid(cmd_valid),
  .cmd_op   (cmd_op),
  .wr_lock  (wr_lock),
  .bod_low  (bod_low),
  .status   (status)
);

// File: tb/nvm_prog_status_tb.sv
module nvm_prog_status_tb;

  localparam int AW = 6;
  localparam int PW = 3;
  localparam int DW = 8;
  localparam int CL = 16;
  localparam int NB = 1 << AW;
  localparam int PB = 1 << PW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          wr_lock;
  logic          bod_low;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic [7:0]    status;

  int checks = 0;
  int errors = 0;
  int busy_cnt = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  nvm_prog_status #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .CYCLE_LEN(CL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wr_lock(wr_lock),
    .bod_low(bod_low), .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
  );

  // behavioural reference model
  logic [7:0] m_mem [NB];
  logic [7:0] m_buf [PB];
  bit         m_msk [PB];
  int         m_last_off;
  logic [7:0] m_last_dat;
  bit         m_active, m_erase, m_load, m_succ;
  int         m_rem, m_page;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
      for (int i = 0; i < PB; i++) begin m_buf[i] = 8'h00; m_msk[i] = 0; end
      m_last_off = 0; m_last_dat = 8'h00;
      m_active = 0; m_erase = 0; m_load = 1; m_succ = 1; m_rem = 0; m_page = 0;
    end else if (m_active) begin
      if (bod_low) begin
        m_active = 0;
        if (!m_erase) for (int i = 0; i < PB; i++) m_msk[i] = 0;
      end else if (m_rem == 0) begin
        for (int i = 0; i < PB; i++) begin
          if (m_erase) m_mem[m_page*PB+i] = 8'hFF;
          else if (m_msk[i]) m_mem[m_page*PB+i] = m_buf[i];
        end
        if (!m_erase) for (int i = 0; i < PB; i++) m_msk[i] = 0;
        m_succ = 1; m_active = 0;
      end else m_rem = m_rem - 1;
    end else if (cmd_valid && !bod_low) begin
      if (cmd_op == 2'b01) begin
        m_buf[cmd_addr % PB] = cmd_data; m_msk[cmd_addr % PB] = 1;
        m_last_off = cmd_addr % PB; m_last_dat = cmd_data; m_load = 0;
      end else if (cmd_op[1] && !wr_lock) begin
        m_active = 1; m_rem = CL - 1; m_succ = 0;
        m_erase = (cmd_op == 2'b11); m_page = cmd_addr / PB;
        if (cmd_op == 2'b10) m_load = 1;
      end
    end
  end

  function automatic logic [7:0] exp_status();
    return {4'h0, m_load, m_succ, !bod_low, !(m_active || bod_low)};
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    if (m_active && (a / PB) == m_page) begin
      if (m_erase) return 8'h7F;
      if ((a % PB) == m_last_off) return m_last_dat ^ 8'h80;
    end
    return m_mem[a];
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock, then compare against the model at the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (!status[0]) busy_cnt++;
    check({phase, " model status"}, status, exp_status());
    check({phase, " model read"}, rd_data, exp_rd(int'(rd_addr)));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send(input logic [1:0] op, input int a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(a); cmd_data = d;
    tick();
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [7:0] exp);
    rd_addr = AW'(a);
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * CL && !status[0]; i++) tick();
  endtask

  bit finished = 0;

  initial begin
    #3000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_addr = '0; cmd_data = '0;
    wr_lock = 1'b0; bod_low = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ticks(4);

    // R1 reset state
    check("R1 reset status", status, 8'h0F);
    rd_chk("R12 erased cell after reset", 0, 8'hFF);

    // R2 load three bytes, last at offset 3
    phase = "R2";
    send(2'b01, 10, 8'h11);
    send(2'b01, 13, 8'h22);
    send(2'b01, 11, 8'hA5);
    check("R2 LOAD low after load", status, 8'h07);

    // R4 program page 1
    phase = "R4";
    busy_cnt = 0;
    send(2'b10, 8, 8'h00);
    check("R4 busy and success low at start", status, 8'h0A);
    rd_chk("R9 poll inverted MSB", 11, 8'h25);
    rd_chk("R10 highest loaded offset not polled", 13, 8'hFF);
    rd_chk("R12 other cell reads array", 10, 8'hFF);
    phase = "R3";
    send(2'b01, 12, 8'h55);
    send(2'b11, 8, 8'h00);
    check("R3 busy commands leave status", status, 8'h0A);
    phase = "R4";
    wait_idle();
    check("R4 busy length", 8'(busy_cnt), 8'(CL));
    check("R5 success after program", status, 8'h0F);
    rd_chk("R9 true value after cycle", 11, 8'hA5);
    rd_chk("R5 loaded byte", 10, 8'h11);
    rd_chk("R5 loaded byte", 13, 8'h22);
    rd_chk("R3 load during busy ignored", 12, 8'hFF);
    rd_chk("R5 unloaded byte kept", 8, 8'hFF);

    // R6 / R11 erase page 1
    phase = "R11";
    send(2'b11, 9, 8'h00);
    check("R11 erase status", status, 8'h0A);
    rd_chk("R11 erase poll", 9, 8'h7F);
    rd_chk("R11 erase poll", 11, 8'h7F);
    rd_chk("R12 other page during erase", 3, 8'hFF);
    phase = "R6";
    wait_idle();
    check("R6 success after erase", status, 8'h0F);
    rd_chk("R6 page erased", 11, 8'hFF);
    rd_chk("R6 page erased", 13, 8'hFF);

    // R3 locked program ignored
    phase = "R3";
    wr_lock = 1'b1;
    send(2'b10, 8, 8'h00);
    check("R3 locked program ignored", status, 8'h0F);
    wr_lock = 1'b0;

    // R7 brownout while idle
    phase = "R7";
    bod_low = 1'b1;
    tick();
    check("R7 brownout flags", status, 8'h0C);
    send(2'b01, 20, 8'h99);
    check("R7 load blocked by brownout", status, 8'h0C);
    bod_low = 1'b0;
    tick();
    check("R7 recovery flags", status, 8'h0F);

    // R8 brownout mid-program
    phase = "R8";
    send(2'b01, 16, 8'h3C);
    send(2'b10, 16, 8'h00);
    rd_chk("R9 poll page 2", 16, 8'hBC);
    ticks(5);
    bod_low = 1'b1;
    tick();
    check("R8 abort flags", status, 8'h08);
    rd_chk("R8 target unchanged", 16, 8'hFF);
    ticks(3);
    bod_low = 1'b0;
    tick();
    check("R8 busy released, failure held", status, 8'h0B);
    ticks(CL + 4);
    check("R8 failure record kept", status, 8'h0B);
    rd_chk("R8 target still unchanged", 16, 8'hFF);

    // R10 retry with out-of-order loads
    phase = "R10";
    send(2'b01, 16, 8'h3C);
    send(2'b01, 23, 8'h01);
    send(2'b01, 17, 8'h77);
    send(2'b10, 16, 8'h00);
    rd_chk("R10 last loaded polled", 17, 8'hF7);
    rd_chk("R10 highest offset not polled", 23, 8'hFF);
    wait_idle();
    check("R5 success after retry", status, 8'h0F);
    rd_chk("R5 retry byte", 16, 8'h3C);
    rd_chk("R5 retry byte", 17, 8'h77);
    rd_chk("R5 retry byte", 23, 8'h01);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule